// File: doc/BRIEF.md
# Windowed Barker Frame-Sync Detector

This block finds the start of a frame in a stream of hard symbol decisions. Every time the symbol strobe is high, the current decision bit enters a 21-stage history. The block correlates that history against a 21-digit sync word. The word is a 7-digit Barker code sent three times, and the third copy is negated. The score is computed as three 7-digit partial sums, which are then combined with signs +, +, −. This keeps the adder fan-in small. The signed score is presented on `corr` after every symbol.

A coarse acquisition stage arms the detector with an expected symbol position. The detector then counts strobes from the arm. It accepts a match only when the symbol index lies within four symbols of that position and the score reaches a programmable 5-bit threshold. A threshold of 16 is the usual setting, because it still accepts a word with two wrong digits.

Each arm produces exactly one event:
- a one-cycle sync pulse, or
- a one-cycle miss pulse, if the window closes without a match. The controller can use the miss to go back to coarse search.

Top module: `frame_sync_detector`

## Requirements
- R1: While reset is high and on the first cycle after it, `corr` is 0, and `sync_pulse` and `miss` are low.
- R2: A strobe (`sym_valid` high at a rising edge) shifts in `sym_bit`. At the next rising edge, `corr` takes the signed sum over the 21 newest bits of +1 per agreement and −1 per disagreement with the sync word.
  - Sync word layout: the 7-digit code 1110010 (1 means +1, 0 means −1), sent three times, with the third copy inverted.
  - Alignment: the oldest of the 21 bits lines up with the first word digit.
- R3: `corr` changes only at the edge after a strobe. Between strobes it holds, whatever `sym_bit` does.
- R4: A received copy of the word gives `corr` = 21. Its bitwise complement gives −21.
- R5: After `arm`, strobes are numbered 1, 2, … A one-cycle `sync_pulse` is issued with the `corr` update of symbol k when both of the following hold:
  - the detector is armed, and |k − `arm_pos`| ≤ 4;
  - `corr` ≥ `thresh`.
- R6: A full-score match outside the window gives no `sync_pulse`.
- R7: At most one `sync_pulse` is issued per arm. Matches after it are ignored until the next `arm`.
- R8: If symbol `arm_pos`+4 is evaluated while armed with no match, `miss` pulses for one cycle in the same cycle as that `corr` update, and the detector disarms. `sync_pulse` and `miss` are never high together.
- R9: The threshold compare is inclusive, and each wrong digit lowers the score by 2:
  - with `thresh` = 16, a word with two wrong digits (score 17) is accepted and one with three wrong digits (score 15) is not;
  - with `thresh` = 15, the three-wrong word is accepted.
- R10: Before any `arm`, or after the event of an arm, no pulse or miss occurs. A new `arm` restarts the count at 0 and takes the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Symbol strobe |
| sym_bit | input | 1 | Hard decision of the symbol (1 = +1) |
| arm | input | 1 | Starts a search window, loads the target |
| arm_pos | input | 8 | Expected symbol index of the word's last digit |
| thresh | input | 5 | Match threshold, unsigned |
| corr | output | 6 | Signed correlation score |
| sync_pulse | output | 1 | One-cycle frame-sync event |
| miss | output | 1 | One-cycle window-expired event |

## Verification
Faults in the history register or in a partial-sum sign show up in `corr` at the edge after the next strobe. A fault in the symbol counter or in the window bounds stays hidden until a word lands near a window edge. Once that happens, the pulse appears one symbol early or late, or a miss replaces it. A fault in the armed flag shows up as a second pulse in the same window, or as a missing miss. For this reason the bench aims words at both window edges and one symbol beyond them, as well as at the target itself.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    // Code geometry; digit 0 of the code sits at the MSB of the pattern.
    localparam int CODE_LEN = 7;
    localparam int REPEATS = 3;
    localparam logic [CODE_LEN-1:0] BARKER_PAT = 7'b1110010;
    // Bit j set: repeat j enters the total with negative sign.
    localparam logic [REPEATS-1:0] REPEAT_NEG = 3'b100;

    localparam int SYNC_LEN = CODE_LEN * REPEATS;
    localparam int CORR_W = $clog2(SYNC_LEN + 1) + 1;
    localparam int THR_W = 5;
    localparam int POS_WIDTH = 8;
    localparam int WIN_HALF_DEF = 4;

    typedef logic signed [CORR_W-1:0] corr_t;

    // Widen an unsigned threshold into the signed score domain.
    function automatic corr_t thr_to_corr(input logic [THR_W-1:0] t);
        return corr_t'({{(CORR_W-THR_W){1'b0}}, t});
    endfunction

endpackage

// File: rtl/fsd_shiftreg.sv
module fsd_shiftreg #(
    parameter int LEN = 21
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] taps
);

    // Newest bit at index 0, oldest at LEN-1.
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (shift_en) begin
            taps <= {taps[LEN-2:0], din};
        end
    end

endmodule

// File: rtl/fsd_subcorr.sv
module fsd_subcorr
    import fsd_pkg::*;
#(
    parameter int           N       = CODE_LEN,
    parameter logic [N-1:0] PATTERN = BARKER_PAT,
    parameter bit           NEGATE  = 1'b0
) (
    input  logic [N-1:0] rx,
    output corr_t        part
);

    corr_t acc;

    always_comb begin
        acc = '0;
        for (int k = 0; k < N; k++) begin
            if (rx[k] == PATTERN[k]) begin
                acc = acc + corr_t'(1);
            end else begin
                acc = acc - corr_t'(1);
            end
        end
        part = NEGATE ? -acc : acc;
    end

endmodule

// File: rtl/fsd_window.sv
module fsd_window
    import fsd_pkg::*;
#(
    parameter int POS_W = POS_WIDTH,
    parameter int HALF  = WIN_HALF_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [POS_W-1:0] arm_pos,
    input  logic             sym_valid,
    input  logic             eval,
    input  logic             hit,
    output logic             sync_pulse,
    output logic             miss
);

    localparam int IW = POS_W + 2;

    typedef struct packed {
        logic          armed;
        logic [IW-1:0] idx;
        logic [IW-1:0] tgt;
    } win_state_t;

    win_state_t    st;
    logic [IW-1:0] hi_edge;
    logic [IW-1:0] lo_reach;
    logic          live;
    logic          in_win;
    logic          at_end;

    assign hi_edge  = st.tgt + IW'(HALF);
    assign lo_reach = st.idx + IW'(HALF);
    assign live     = st.armed && (st.idx != '0);
    assign in_win   = live && (lo_reach >= st.tgt) && (st.idx <= hi_edge);
    assign at_end   = live && (st.idx >= hi_edge);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= '0;
            sync_pulse <= 1'b0;
            miss       <= 1'b0;
        end else begin
            sync_pulse <= 1'b0;
            miss       <= 1'b0;
            if (arm) begin
                st.armed <= 1'b1;
                st.idx   <= '0;
                st.tgt   <= IW'(arm_pos);
            end else begin
                if (sym_valid && st.armed) begin
                    st.idx <= st.idx + IW'(1);
                end
                if (eval) begin
                    if (in_win && hit) begin
                        sync_pulse <= 1'b1;
                        st.armed   <= 1'b0;
                    end else if (at_end) begin
                        miss     <= 1'b1;
                        st.armed <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/frame_sync_detector.sv
module frame_sync_detector
    import fsd_pkg::*;
#(
    parameter int POS_W    = POS_WIDTH,
    parameter int WIN_HALF = WIN_HALF_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sym_valid,
    input  logic                     sym_bit,
    input  logic                     arm,
    input  logic [POS_W-1:0]         arm_pos,
    input  logic [THR_W-1:0]         thresh,
    output logic signed [CORR_W-1:0] corr,
    output logic                     sync_pulse,
    output logic                     miss
);

    logic [SYNC_LEN-1:0] taps;
    corr_t               part [REPEATS];
    corr_t               total;
    logic                eval_q;
    logic                hit;

    fsd_shiftreg #(.LEN(SYNC_LEN)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sym_valid),
        .din      (sym_bit),
        .taps     (taps)
    );

    // One partial correlator per code repeat; oldest repeat at the top taps.
    for (genvar j = 0; j < REPEATS; j++) begin : g_rep
        fsd_subcorr #(
            .N       (CODE_LEN),
            .PATTERN (BARKER_PAT),
            .NEGATE  (REPEAT_NEG[j])
        ) u_part (
            .rx   (taps[SYNC_LEN-1-CODE_LEN*j -: CODE_LEN]),
            .part (part[j])
        );
    end

    always_comb begin
        total = '0;
        for (int j = 0; j < REPEATS; j++) begin
            total = total + part[j];
        end
    end

    assign hit = (total >= thr_to_corr(thresh));

    always_ff @(posedge clk) begin
        if (rst) begin
            eval_q <= 1'b0;
            corr   <= '0;
        end else begin
            eval_q <= sym_valid;
            if (eval_q) begin
                corr <= total;
            end
        end
    end

    fsd_window #(.POS_W(POS_W), .HALF(WIN_HALF)) u_win (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .arm_pos    (arm_pos),
        .sym_valid  (sym_valid),
        .eval       (eval_q),
        .hit        (hit),
        .sync_pulse (sync_pulse),
        .miss       (miss)
    );

endmodule

// File: rtl/fsd_checker.sv
module fsd_checker
    import fsd_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     sym_valid,
    input logic [THR_W-1:0]         thresh,
    input logic signed [CORR_W-1:0] corr,
    input logic                     sync_pulse,
    input logic                     miss
);

    localparam corr_t PEAK_C = corr_t'(SYNC_LEN);

    AST_CORR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (corr <= PEAK_C) && (corr >= -PEAK_C)); // R2

    AST_CORR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> ##1 $stable(corr)); // R3

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse); // R7

    AST_PULSE_THRESH: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> (corr >= thr_to_corr($past(thresh)))); // R9

    AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sync_pulse && miss)); // R8

    AST_MISS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        miss |=> !miss); // R8

    AST_EVENT_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        (sync_pulse || miss) |-> $past(sym_valid, 2)); // R5

endmodule

bind frame_sync_detector fsd_checker i_fsd_chk (
    .clk        (clk),
    .rst        (rst),
    .sym_valid  (sym_valid),
    .thresh     (thresh),
    .corr       (corr),
    .sync_pulse (sync_pulse),
    .miss       (miss)
);

// File: tb/test_frame_sync_detector.sv
module test_frame_sync_detector;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sym_valid = 1'b0;
    logic              sym_bit = 1'b0;
    logic              arm = 1'b0;
    logic [7:0]        arm_pos = '0;
    logic [4:0]        thresh = 5'd16;
    logic signed [5:0] corr;
    logic              sync_pulse;
    logic              miss;

    always #10 clk = ~clk;

    frame_sync_detector i_frame_sync_detector (
        .clk        (clk),
        .rst        (rst),
        .sym_valid  (sym_valid),
        .sym_bit    (sym_bit),
        .arm        (arm),
        .arm_pos    (arm_pos),
        .thresh     (thresh),
        .corr       (corr),
        .sync_pulse (sync_pulse),
        .miss       (miss)
    );

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 0;
    int  pulse_cnt = 0;
    int  miss_cnt = 0;
    int  wd [21];
    bit  wbit [21];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        int bk [7];
        bk = '{1, 1, 1, -1, -1, 1, -1};
        for (int i = 0; i < 21; i++) begin
            wd[i] = bk[i % 7] * ((i / 7 == 2) ? -1 : 1);
            wbit[i] = (wd[i] > 0);
        end
    end

    // Behavioural reference model
    bit q[$];
    int m_corr, m_idx, m_tgt;
    bit m_pulse, m_miss, m_eval, m_armed;

    always @(posedge clk) begin
        int c, oi;
        bit a0, np, nm;
        if (rst) begin
            q.delete();
            for (int i = 0; i < 21; i++) q.push_back(1'b0);
            m_corr = 0; m_pulse = 0; m_miss = 0; m_eval = 0;
            m_armed = 0; m_idx = 0; m_tgt = 0;
        end else begin
            c = 0;
            for (int i = 0; i < 21; i++) c += wd[i] * (q[i] ? 1 : -1);
            np = 0; nm = 0;
            if (m_eval) m_corr = c;
            if (arm) begin
                m_armed = 1; m_idx = 0; m_tgt = int'(arm_pos);
            end else begin
                a0 = m_armed; oi = m_idx;
                if (m_eval && a0 && oi != 0) begin
                    if (oi + 4 >= m_tgt && oi <= m_tgt + 4 && c >= int'(thresh)) begin
                        np = 1; m_armed = 0;
                    end else if (oi >= m_tgt + 4) begin
                        nm = 1; m_armed = 0;
                    end
                end
                if (sym_valid && a0) m_idx = oi + 1;
            end
            if (sym_valid) begin
                q.push_back(sym_bit);
                void'(q.pop_front());
            end
            m_eval = sym_valid;
            m_pulse = np;
            m_miss = nm;
        end
    end

    // Per-cycle comparison and event counting
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(int'(corr) == m_corr, "R2 corr vs model", int'(corr), m_corr);
            chk(sync_pulse == m_pulse, "R5 sync_pulse vs model", int'(sync_pulse), int'(m_pulse));
            chk(miss == m_miss, "R8 miss vs model", int'(miss), int'(m_miss));
            if (sync_pulse) pulse_cnt++;
            if (miss) miss_cnt++;
        end
    end

    task automatic send(input bit b, input bit gap = 1'b1);
        sym_valid = 1'b1;
        sym_bit = b;
        @(negedge clk);
        sym_valid = 1'b0;
        if (gap) @(negedge clk);
    endtask

    task automatic send_word(input logic [20:0] flip, input bit gap = 1'b1);
        for (int i = 0; i < 21; i++) send(wbit[i] ^ flip[i], gap);
        if (!gap) @(negedge clk);
    endtask

    task automatic fill(input int n, input bit v);
        for (int i = 0; i < n; i++) send(v);
    endtask

    task automatic arm_at(input int p);
        arm = 1'b1;
        arm_pos = 8'(p);
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int pb, mb;
        int held;
        repeat (3) @(negedge clk);
        chk(corr == 0 && !sync_pulse && !miss, "R1 outputs during reset", int'(corr), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(corr == 0, "R1 corr after reset", int'(corr), 0);
        chk(!sync_pulse && !miss, "R1 events after reset", int'(sync_pulse) + int'(miss), 0);

        // R4 / R10: full word without arm
        pb = pulse_cnt; mb = miss_cnt;
        send_word(21'h0);
        settle();
        chk(corr == 21, "R4 exact word score", int'(corr), 21);
        chk(pulse_cnt == pb && miss_cnt == mb, "R10 no event when unarmed", pulse_cnt - pb, 0);
        send_word(21'h1FFFFF);
        settle();
        chk(corr == -21, "R4 complement score", int'(corr), -21);

        // R3: hold between strobes while sym_bit toggles
        held = int'(corr);
        for (int i = 0; i < 6; i++) begin
            sym_bit = ~sym_bit;
            @(negedge clk);
        end
        chk(int'(corr) == held, "R3 corr holds without strobe", int'(corr), held);

        // R5: match at the target
        thresh = 5'd16;
        pb = pulse_cnt; mb = miss_cnt;
        arm_at(30); fill(9, 0); send_word(21'h0); settle();
        chk(pulse_cnt - pb == 1, "R5 pulse at target", pulse_cnt - pb, 1);
        chk(miss_cnt == mb, "R5 no miss on match", miss_cnt - mb, 0);

        // R9: two wrong digits accepted
        pb = pulse_cnt;
        arm_at(25); fill(4, 0); send_word(21'h000408); settle();
        chk(corr == 17, "R9 two-wrong score", int'(corr), 17);
        chk(pulse_cnt - pb == 1, "R9 two-wrong accepted", pulse_cnt - pb, 1);

        // R9: three wrong digits rejected at 16, window then expires
        pb = pulse_cnt; mb = miss_cnt;
        arm_at(25); fill(4, 0); send_word(21'h040408); settle();
        chk(corr == 15, "R9 three-wrong score", int'(corr), 15);
        chk(pulse_cnt == pb, "R9 three-wrong rejected", pulse_cnt - pb, 0);
        fill(4, 0); settle();
        chk(miss_cnt - mb == 1, "R8 miss after rejection", miss_cnt - mb, 1);

        // R9: inclusive compare at 15
        thresh = 5'd15;
        pb = pulse_cnt;
        arm_at(25); fill(4, 0); send_word(21'h040408); settle();
        chk(pulse_cnt - pb == 1, "R9 equal to threshold accepted", pulse_cnt - pb, 1);

        // R6: full match outside the window, then R8 miss
        thresh = 5'd16;
        pb = pulse_cnt; mb = miss_cnt;
        arm_at(40); fill(9, 0); send_word(21'h0); settle();
        chk(pulse_cnt == pb, "R6 no pulse outside window", pulse_cnt - pb, 0);
        fill(14, 0); settle();
        chk(miss_cnt - mb == 1, "R8 miss at window end", miss_cnt - mb, 1);
        chk(pulse_cnt == pb, "R6 still no pulse", pulse_cnt - pb, 0);

        // R5: window edges
        pb = pulse_cnt;
        arm_at(30); fill(5, 0); send_word(21'h0); settle();
        chk(pulse_cnt - pb == 1, "R5 lower window edge", pulse_cnt - pb, 1);
        pb = pulse_cnt;
        arm_at(30); fill(13, 0); send_word(21'h0); settle();
        chk(pulse_cnt - pb == 1, "R5 upper window edge", pulse_cnt - pb, 1);
        pb = pulse_cnt; mb = miss_cnt;
        arm_at(30); fill(14, 0); send_word(21'h0); settle();
        chk(pulse_cnt == pb, "R8 one past window no pulse", pulse_cnt - pb, 0);
        chk(miss_cnt - mb == 1, "R8 one past window miss", miss_cnt - mb, 1);

        // R7: one pulse per arm even with permissive threshold
        thresh = 5'd0;
        pb = pulse_cnt; mb = miss_cnt;
        arm_at(22); fill(1, 0); send_word(21'h0); fill(10, 1); settle();
        chk(pulse_cnt - pb == 1, "R7 single pulse per arm", pulse_cnt - pb, 1);
        chk(miss_cnt == mb, "R7 no miss after pulse", miss_cnt - mb, 0);

        // R10: re-arm restarts the count
        thresh = 5'd16;
        pb = pulse_cnt; mb = miss_cnt;
        arm_at(50); fill(10, 0); arm_at(25); fill(4, 0); send_word(21'h0); settle();
        chk(pulse_cnt - pb == 1, "R10 re-arm uses new target", pulse_cnt - pb, 1);
        chk(miss_cnt == mb, "R10 no miss after re-arm", miss_cnt - mb, 0);

        // R2: back-to-back strobes
        send_word(21'h0, 1'b0); settle();
        chk(corr == 21, "R2 back-to-back strobes", int'(corr), 21);

        // Random stream against the model
        for (int n = 0; n < 1500; n++) begin
            sym_valid = 1'($urandom_range(0, 1));
            sym_bit = 1'($urandom_range(0, 1));
            arm = ($urandom_range(0, 39) == 0);
            arm_pos = 8'($urandom_range(18, 60));
            if ($urandom_range(0, 49) == 0) thresh = 5'($urandom_range(0, 21));
            @(negedge clk);
        end
        sym_valid = 1'b0;
        arm = 1'b0;
        settle();

        done = 1;
        summary();
        $finish;
    end

endmodule